// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Bypass Routing

This block sits between up to 32 level-sensitive interrupt sources and a parent interrupt controller. Each source has one bit in a 32-bit enable word and one bit in a 32-bit status word, and both words are reached over a small register bus. Group masks are fixed when the block is built. Each mask picks the sources that are ORed onto one parent line. A source only counts toward its line while it is both pending and enabled.

A build-time forward mask marks sources, such as UART lines, that skip the controller. A forwarded source drives its own parent line straight from its pin. Its enable bit and its group membership have no effect on that line. A source whose forward bit is clear goes through the normal gated path and joins whichever group mask names it. Bits that no mask names are treated as unconnected: they read as zero and they never raise an output. Software changes the enable word by writing the whole word, because there are no set or clear aliases.

Top module: `irqmux_l2`

## Requirements
- R1: After reset the enable word reads as 0 and every group output is 0.
- R2: A write to byte offset 0x0 replaces the whole enable word with the written data from the next clock on. Bits of unconnected sources read back as 0.
- R3: A read of byte offset 0x4 returns the current source levels masked to connected sources. Unconnected bits read as 0.
- R4: Writes to offset 0x4, and writes to any offset other than 0x0, leave the enable word unchanged.
- R5: Group output k equals, one clock after its inputs, the OR over sources of (level AND enable AND group mask k AND NOT forward).
- R6: For each forwarded source i, bit i of the forward output follows the source pin combinationally, whatever its enable bit is. Bits of non-forwarded sources on the forward output are always 0.
- R7: A forwarded source never raises a group output, even when a group mask names it.
- R8: A source whose forward bit is clear and that a group mask names contributes to that group like any other source.
- R9: An unconnected source never raises a group output, a forward output or a status bit.
- R10: Reads of offsets other than 0x0 and 0x4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive source lines |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| grp_irq_o | output | 2 | Gated group lines to the parent |
| fwd_irq_o | output | 32 | Bypass lines, one per source |

## Verification
The bench sweeps single sources across both group masks and the forward mask. This catches a design that routes a source to the wrong line, or that lets a forwarded source leak into its group. A second build, with source 0 forwarded and sources 1 and 2 placed in group A, shows whether a non-forwarded mux source joins its group and whether the forward bit overrides group membership. Directed cases write the whole enable word, write to the status offset and to an unused offset, and drive unconnected pins high. A design that stores unconnected enable bits, accepts status writes or decodes addresses loosely shows up in these cases as wrong read-back or a spurious output. Random source levels and enable words then compare every output against a bench model one clock later.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned ADDR_W  = 4;
   localparam logic [ADDR_W-1:0] OFF_ENABLE = 4'h0;
   localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h4;

   typedef enum logic [1:0] {
      SEL_ENABLE,
      SEL_STATUS,
      SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
      if (a == OFF_ENABLE)      return SEL_ENABLE;
      else if (a == OFF_STATUS) return SEL_STATUS;
      else                      return SEL_NONE;
   endfunction
endpackage

// File: rtl/irqmux_enable.sv
module irqmux_enable
   import irqmux_pkg::*;
#(
   parameter int unsigned        NUM_SRC = 32,
   parameter logic [NUM_SRC-1:0] VALID   = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SRC-1:0] en_q
);
   logic hit;
   assign hit = wr && (decode_addr(addr) == SEL_ENABLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   en_q <= '0;
      else if (hit) en_q <= wdata[NUM_SRC-1:0] & VALID;
   end

   assert_en_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (en_q == '0));
   assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFF_ENABLE) |=> (en_q == ($past(wdata[NUM_SRC-1:0]) & VALID)));
   assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || addr != OFF_ENABLE) |=> $stable(en_q));
endmodule

// File: rtl/irqmux_group.sv
module irqmux_group #(
   parameter int unsigned                      NUM_SRC  = 32,
   parameter int unsigned                      NUM_GRP  = 2,
   parameter logic [NUM_GRP-1:0][NUM_SRC-1:0]  GRP_MASK = '0,
   parameter logic [NUM_SRC-1:0]               FWD_MASK = '0,
   parameter bit                               REG_OUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic [NUM_SRC-1:0] en,
   output logic [NUM_GRP-1:0] grp_o
);
   logic [NUM_GRP-1:0] grp_d;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam logic [NUM_SRC-1:0] EFF = GRP_MASK[g] & ~FWD_MASK;
      assign grp_d[g] = |(src & en & EFF);

      if (REG_OUT) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= grp_d[g];
         end
         assign grp_o[g] = q;

         assert_grp_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past((en & EFF) == '0)) |-> !grp_o[g]);
         assert_grp_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past((src & EFF) == '0)) |-> !grp_o[g]);
      end else begin : g_comb
         assign grp_o[g] = grp_d[g];
      end
   end
endmodule

// File: rtl/irqmux_bypass.sv
module irqmux_bypass #(
   parameter int unsigned        NUM_SRC  = 32,
   parameter logic [NUM_SRC-1:0] FWD_MASK = '0
) (
   input  logic [NUM_SRC-1:0] src,
   output logic [NUM_SRC-1:0] fwd_o
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (FWD_MASK[i]) begin : g_pass
         assign fwd_o[i] = src[i];
      end else begin : g_tie
         assign fwd_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irqmux_l2.sv
module irqmux_l2
   import irqmux_pkg::*;
#(
   parameter int unsigned                      NUM_SRC  = 32,
   parameter int unsigned                      NUM_GRP  = 2,
   parameter logic [NUM_GRP-1:0][NUM_SRC-1:0]  GRP_MASK = {32'h0000_0140, 32'h0000_0EB8},
   parameter logic [NUM_SRC-1:0]               FWD_MASK = 32'h0000_0007,
   parameter bit                               REG_OUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        src_i,
   input  logic [3:0]         reg_addr,
   input  logic               reg_wr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic [NUM_GRP-1:0] grp_irq_o,
   output logic [31:0]        fwd_irq_o
);
   function automatic logic [NUM_SRC-1:0] f_valid();
      logic [NUM_SRC-1:0] v = FWD_MASK;
      for (int g = 0; g < NUM_GRP; g++) v |= GRP_MASK[g];
      return v;
   endfunction

   function automatic logic [NUM_SRC-1:0] f_overlap();
      logic [NUM_SRC-1:0] seen = '0;
      logic [NUM_SRC-1:0] dup  = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         dup  |= seen & GRP_MASK[g];
         seen |= GRP_MASK[g];
      end
      return dup;
   endfunction

   localparam logic [NUM_SRC-1:0] VALID = f_valid();
   localparam logic [NUM_SRC-1:0] DUP   = f_overlap();

   if (NUM_SRC != DATA_W) begin : g_bad_width
      $error("irqmux_l2: NUM_SRC must equal the register width");
   end
   if (NUM_GRP < 1) begin : g_bad_grp
      $error("irqmux_l2: at least one group output is required");
   end
   if (DUP != '0) begin : g_bad_overlap
      $error("irqmux_l2: a source is named by more than one group mask");
   end

   logic [NUM_SRC-1:0] src_v;
   logic [NUM_SRC-1:0] en_q;

   assign src_v = src_i[NUM_SRC-1:0] & VALID;

   irqmux_enable #(.NUM_SRC(NUM_SRC), .VALID(VALID)) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .en_q  (en_q)
   );

   irqmux_group #(
      .NUM_SRC  (NUM_SRC),
      .NUM_GRP  (NUM_GRP),
      .GRP_MASK (GRP_MASK),
      .FWD_MASK (FWD_MASK),
      .REG_OUT  (REG_OUT)
   ) u_group (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_v),
      .en    (en_q),
      .grp_o (grp_irq_o)
   );

   irqmux_bypass #(.NUM_SRC(NUM_SRC), .FWD_MASK(FWD_MASK)) u_bypass (
      .src   (src_i[NUM_SRC-1:0]),
      .fwd_o (fwd_irq_o)
   );

   always_comb begin
      unique case (decode_addr(reg_addr))
         SEL_ENABLE: reg_rdata = en_q;
         SEL_STATUS: reg_rdata = src_v;
         default:    reg_rdata = '0;
      endcase
   end

   assert_status_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFF_STATUS) |-> ((reg_rdata & ~VALID) == '0));
   assert_fwd_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((fwd_irq_o & ~FWD_MASK) == '0));
   assert_unused_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != OFF_STATUS && reg_addr != OFF_ENABLE) |-> (reg_rdata == '0));
   assert_unconn_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q & ~VALID) == '0));
endmodule

// File: tb/irqmux_l2_bench.sv
module irqmux_l2_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] MA_A = 32'h0000_0EB8, MA_B = 32'h0000_0140, MA_F = 32'h0000_0007;
   localparam logic [31:0] AL_A = 32'h0000_0EBF, AL_B = 32'h0000_0140, AL_F = 32'h0000_0001;
   localparam logic [31:0] VAL  = 32'h0000_0FFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] src = '0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata_alt, fwd, fwd_alt;
   logic [1:0]  grp, grp_alt;
   logic [31:0] en_m = '0;
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irqmux_l2 u_irqmux_l2 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr(addr), .reg_wr(wr),
      .reg_wdata(wdata), .reg_rdata(rdata), .grp_irq_o(grp), .fwd_irq_o(fwd));

   irqmux_l2 #(.GRP_MASK({AL_B, AL_A}), .FWD_MASK(AL_F)) u_alt (
      .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr(addr), .reg_wr(wr),
      .reg_wdata(wdata), .reg_rdata(rdata_alt), .grp_irq_o(grp_alt), .fwd_irq_o(fwd_alt));

   function automatic logic [1:0] exp_grp(input logic [31:0] s, e, a, b, f);
      return {|(s & e & b & ~f), |(s & e & a & ~f)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; addr = 4'h0;
      if (a == 4'h0) en_m = d & VAL;
   endtask

   task automatic apply_and_check(input logic [31:0] s, input string req);
      src = s;
      addr = 4'h4;
      #1;
      check({req, " R3 status"}, rdata, s & VAL);
      check({req, " R6 fwd"}, fwd, s & MA_F);
      check({req, " R6 fwd alt"}, fwd_alt, s & AL_F);
      @(negedge clk);
      check({req, " R5 grp"}, {30'd0, grp}, {30'd0, exp_grp(s, en_m, MA_A, MA_B, MA_F)});
      check({req, " R8 grp alt"}, {30'd0, grp_alt}, {30'd0, exp_grp(s, en_m, AL_A, AL_B, AL_F)});
      addr = 4'h0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1 enable reset", rdata, 32'h0);
      check("R1 grp reset", {30'd0, grp}, 32'h0);

      reg_write(4'h0, 32'hFFFF_FFFF);
      #1;
      check("R2 enable unconnected bits", rdata, 32'h0000_0FFF);
      reg_write(4'h4, 32'h0);
      #1;
      check("R4 status write ignored", rdata, 32'h0000_0FFF);
      reg_write(4'h8, 32'h0);
      #1;
      check("R4 unused write ignored", rdata, 32'h0000_0FFF);
      addr = 4'h8;
      #1;
      check("R10 unused read", rdata, 32'h0);
      addr = 4'hC;
      #1;
      check("R10 unused read C", rdata, 32'h0);
      addr = 4'h0;

      apply_and_check(32'hFFFF_F000, "R9 unconnected high");
      check("R9 no grp", {30'd0, grp}, 32'h0);
      apply_and_check(32'h0000_0001, "R7 src0 forwarded");
      check("R7 alt src0 not in grp", {30'd0, grp_alt}, 32'h0);
      apply_and_check(32'h0000_0002, "R8 src1 joins alt grp");
      check("R8 alt grp A", {30'd0, grp_alt}, 32'h1);

      reg_write(4'h0, 32'h0);
      apply_and_check(32'h0000_0007, "R6 fwd with enable 0");

      reg_write(4'h0, 32'h0000_0FFF);
      for (int i = 0; i < 32; i++) apply_and_check(32'h1 << i, "R5 sweep");

      for (int i = 0; i < 200; i++) begin
         if ($urandom_range(0, 3) == 0) reg_write(4'h0, $urandom());
         apply_and_check($urandom(), "R5 random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      process::self().srandom(32'h5eed);
   end

   initial begin
      #(CLK_PERIOD * 20000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule